// File: doc/BRIEF.md
# Shared-Operator Nine-Operand Reducer

This block folds nine 32-bit operands into one 32-bit result with an associative two-input operator. A full tree needs eight operator instances. This block uses only six, which run on a fixed four-cycle modulo schedule. In each period the block accepts up to three operand sets, in the first three phases. In the fourth phase it takes no input. It therefore gives three quarters of a full tree's throughput for three quarters of its operators.

Each operator's output goes into its own register. Partial results, and operands that the schedule uses late, stay in holding registers until their slot comes around. The operand order a, b, ..., i is kept through the whole schedule, so the operator only has to be associative and need not be commutative. A set taken in the first or second phase of a period leaves the block five cycles after acceptance. A set taken in the third phase leaves six cycles after acceptance. Under this timing, results always appear in the order their sets were accepted. The phase counter stops when nothing is in flight and no set is offered.

The operator treats a word as an affine map on 16-bit integers: bits [31:16] hold the multiplier and bits [15:0] hold the offset. Combining x then y gives multiplier = my·mx and offset = my·ox + oy, both mod 2^16. This operation is associative but not commutative.

Top module: `fold9_share`

## Requirements
- R1: While reset is held and in the first cycle after it is released, outValid is 0 and inReady is 1 (the phase counter starts at phase 0).
- R2: While the schedule runs, inReady is low in phase 3 of each period and high in phases 0 to 2. A set offered in phase 3 is not accepted.
- R3: Each result equals the left-to-right fold a·b·c·...·i of its set's operands, where operand a is inOperands[0] and i is inOperands[8]. The fold uses x·y = {my·mx, my·ox + oy} mod 2^16, with m in bits [31:16] and o in bits [15:0].
- R4: outValid is high for exactly one cycle per accepted set and at no other time. Results appear in acceptance order.
- R5: A set accepted in phase 0 or 1 appears at the output 5 cycles after the accepting cycle. A set accepted in phase 2 appears 6 cycles after it.
- R6: With inValid held high, the block accepts exactly 3 sets in every 4 consecutive cycles.
- R7: A set held on the inputs while inReady is low produces no result of its own. It is taken only once inReady returns.
- R8: When no set is in flight and inValid is low, the phase stays where it is. Sets offered after such a pause are timed from the held phase.
- R9: If some of the three accepting slots in a period are left empty, the sets in the other slots still produce correct results with R5 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An operand set is offered |
| inReady | output | 1 | The block takes a set this cycle if inValid is high |
| inOperands | input | 9x32 | Operand set, entry 0 is the first operand of the fold |
| outValid | output | 1 | outData holds a finished result this cycle |
| outData | output | 32 | Folded result |

## Verification
The bench uses an operator that is not commutative. A design that swaps the two inputs at any of the 24 slots of the schedule, or that reads a holding register after it has been overwritten, gives a wrong word for the set in that slot. A long stream with valid held high checks the 3-in-4 acceptance rate and the one-cycle difference in latency between the third slot and the first two. Wrong latency bookkeeping would show up as results that are early, late, or out of order. Sparse and paused traffic checks that empty slots make no output pulses and that a halted phase counter restarts without losing its place.

// File: rtl/fold9_pkg.sv
package fold9_pkg;

  localparam int WORD_W  = 32;
  localparam int HALF_W  = WORD_W / 2;
  localparam int NUM_IN  = 9;
  localparam int NUM_OPS = 6;
  localparam int PERIOD  = 4;
  localparam int PH_W    = $clog2(PERIOD);

  typedef enum logic [PH_W-1:0] {PH_A, PH_B, PH_C, PH_D} phaseT;

  // Strobes from control to datapath
  typedef struct packed {
    logic [PERIOD-1:0] phOh;     // one-hot schedule phase
    logic              grabI1;   // set accepted in phase 0: keep its last operand
    logic              grabI2;   // set accepted in phase 1: keep its last operand
    logic              grabLate; // set accepted in phase 2: keep operands e..i
  } strobeT;

  // Associative, non-commutative step: affine map x followed by y
  function automatic logic [WORD_W-1:0] foldStep(input logic [WORD_W-1:0] x,
                                                 input logic [WORD_W-1:0] y);
    logic [HALF_W-1:0]   mx, ox, my, oy;
    logic [2*HALF_W-1:0] prodM, prodO;
    mx = x[WORD_W-1:HALF_W];
    ox = x[HALF_W-1:0];
    my = y[WORD_W-1:HALF_W];
    oy = y[HALF_W-1:0];
    prodM = my * mx;
    prodO = my * ox;
    return {prodM[HALF_W-1:0], prodO[HALF_W-1:0] + oy};
  endfunction

endpackage

// File: rtl/fold9_unit.sv
module fold9_unit
  import fold9_pkg::*;
(
  input  logic [WORD_W-1:0] x,
  input  logic [WORD_W-1:0] y,
  output logic [WORD_W-1:0] z
);
  assign z = foldStep(x, y);
endmodule

// File: rtl/fold9_ctrl.sv
module fold9_ctrl
  import fold9_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  output logic   inReady,
  output logic   outValid,
  output strobeT strobe
);
  localparam int HistLen  = PERIOD + 2;   // longest latency in cycles
  localparam int ShortLat = PERIOD + 1;   // latency of slots 0 and 1

  phaseT               phase;
  logic [HistLen-1:0]  hist;              // hist[j]: accepted j+1 cycles ago
  logic                accept, inFlight, advance;

  assign inReady  = (phase != PH_D);
  assign accept   = inValid && inReady;
  assign inFlight = |hist;
  assign advance  = inValid || inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_A;
      hist  <= '0;
    end else begin
      hist <= {hist[HistLen-2:0], accept};
      if (advance) phase <= phaseT'(phase + 2'd1);
    end
  end

  always_comb begin
    strobe.phOh     = {{(PERIOD-1){1'b0}}, 1'b1} << phase;
    strobe.grabI1   = accept && (phase == PH_A);
    strobe.grabI2   = accept && (phase == PH_B);
    strobe.grabLate = accept && (phase == PH_C);
  end

  assign outValid = ((phase == PH_B || phase == PH_C) && hist[ShortLat-1])
                 || ((phase == PH_A) && hist[HistLen-1]);

  // R2: an offer in the idle phase never enters the schedule
  assert_idle_phase_blocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_D) |=> !hist[0]);

  // R6: never more than three acceptances in any four cycles
  assert_rate_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(hist[PERIOD-1:0]) <= 3);

  // R5: latency of the early slots
  assert_early_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && phase != PH_C) |-> ##5 outValid);

  // R5: latency of the third slot
  assert_late_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accept && phase == PH_C) |-> ##6 outValid);

endmodule

// File: rtl/fold9_datapath.sv
module fold9_datapath
  import fold9_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobeT                        strobe,
  input  logic [NUM_IN-1:0][WORD_W-1:0] opnd,
  output logic [WORD_W-1:0]             outData
);
  typedef logic [WORD_W-1:0] wordT;

  wordT acc  [NUM_OPS];
  wordT opA  [NUM_OPS];
  wordT opB  [NUM_OPS];
  wordT opZ  [NUM_OPS];
  wordT holdE, holdF, holdG, holdH, holdI1, holdI2, holdI3;
  wordT holdAbcd, holdEfgh, resHold;
  logic p0, p1, p2, p3;

  assign {p3, p2, p1, p0} = strobe.phOh;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    fold9_unit u_op (.x(opA[k]), .y(opB[k]), .z(opZ[k]));
  end

  always_comb begin
    // op 1: a.b in phases 0..2, (ab).(cd) of slot 2 in phase 3
    opA[0] = p3 ? acc[0] : opnd[0];
    opB[0] = p3 ? acc[1] : opnd[1];
    // op 2: c.d in phases 0..2, abcd.(efghi) of old slot 2 in phase 3
    opA[1] = p3 ? holdAbcd : opnd[2];
    opB[1] = p3 ? acc[5]   : opnd[3];
    // op 3: e.f live, (ab).(cd) of slot 1, e.f of slot 2 from holds
    opA[2] = p2 ? acc[0] : (p3 ? holdE : opnd[4]);
    opB[2] = p2 ? acc[1] : (p3 ? holdF : opnd[5]);
    // op 4: g.h live, (ef).(gh) of slot 1, g.h of slot 2 from holds
    opA[3] = p2 ? acc[2] : (p3 ? holdG : opnd[6]);
    opB[3] = p2 ? acc[3] : (p3 ? holdH : opnd[7]);
    // op 5: efgh (slot 2), abcd (slot 0), abcdefgh (slot 0), abcdefgh (slot 1)
    opA[4] = p1 ? acc[0] : (p2 ? acc[4] : acc[2]);
    opB[4] = p1 ? acc[1] : (p2 ? acc[5] : acc[3]);
    // op 6: final slot 1, efgh slot 0, efgh.i slot 2, final slot 0
    opA[5] = p1 ? acc[2] : (p2 ? holdEfgh : acc[4]);
    opB[5] = p0 ? holdI2 : (p1 ? acc[3] : (p2 ? holdI3 : holdI1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_OPS; k++) acc[k] <= '0;
      {holdE, holdF, holdG, holdH, holdI3} <= '0;
      holdI1   <= '0;
      holdI2   <= '0;
      holdAbcd <= '0;
      holdEfgh <= '0;
      resHold  <= '0;
    end else begin
      for (int k = 0; k < NUM_OPS; k++) acc[k] <= opZ[k];
      if (strobe.grabI1)   holdI1 <= opnd[8];
      if (strobe.grabI2)   holdI2 <= opnd[8];
      if (strobe.grabLate) {holdE, holdF, holdG, holdH, holdI3} <=
                             {opnd[4], opnd[5], opnd[6], opnd[7], opnd[8]};
      if (p0)      holdAbcd <= acc[0];
      if (p1)      holdEfgh <= acc[4];
      if (p0 || p1) resHold <= acc[5];
    end
  end

  assign outData = p0 ? acc[1] : resHold;

  // R2: control presents exactly one phase at a time
  assert_single_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(strobe.phOh) == 1);

  // R3: slot-0 last operand survives the idle phase until it is consumed
  assert_hold_i1_R3: assert property (@(posedge clk) disable iff (!rstN)
    p3 |=> $stable(holdI1));

  // R3: slot-2 late operands are not disturbed while op 3/4 read them
  assert_hold_late_R3: assert property (@(posedge clk) disable iff (!rstN)
    p3 |=> ($stable(holdE) && $stable(holdH)));

endmodule

// File: rtl/fold9_share.sv
module fold9_share
  import fold9_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  output logic                          inReady,
  input  logic [NUM_IN-1:0][WORD_W-1:0] inOperands,
  output logic                          outValid,
  output logic [WORD_W-1:0]             outData
);
  strobeT strobe;

  fold9_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  fold9_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opnd    (inOperands),
    .outData (outData)
  );
endmodule

// File: tb/sim_fold9_share.sv
`timescale 1ns/1ps
module sim_fold9_share;
  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic              inReady;
  logic [8:0][31:0]  inOperands;
  logic              outValid;
  logic [31:0]       outData;

  always #2 clk = ~clk;   // 250 MHz

  fold9_share u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOperands(inOperands), .outValid(outValid), .outData(outData)
  );

  typedef struct { int due; logic [31:0] val; } expT;
  expT expQ[$];
  int  checks = 0, failures = 0, cyc = 0;
  int  benchPh = 0, lastAcc = -100, accCount = 0, outCount = 0;
  bit  finished = 0;

  always @(posedge clk) cyc++;

  function automatic logic [31:0] refStep(logic [31:0] x, logic [31:0] y);
    logic [31:0] m, o;
    m = (32'(x[31:16]) * 32'(y[31:16])) & 32'h0000_FFFF;
    o = (32'(y[31:16]) * 32'(x[15:0]) + 32'(y[15:0])) & 32'h0000_FFFF;
    return {m[15:0], o[15:0]};
  endfunction

  function automatic logic [31:0] refFold(logic [8:0][31:0] d);
    logic [31:0] r = d[0];
    for (int k = 1; k < 9; k++) r = refStep(r, d[k]);
    return r;
  endfunction

  function automatic logic [8:0][31:0] randSet();
    logic [8:0][31:0] d;
    for (int k = 0; k < 9; k++) d[k] = $urandom();
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // Output comparison for the current cycle (R3, R4, R5)
  task automatic checkOut();
    if (expQ.size() > 0 && expQ[0].due == cyc) begin
      check(outValid === 1'b1, "R4 R5 valid", {31'b0, outValid}, 32'd1);
      check(outData === expQ[0].val, "R3 data", outData, expQ[0].val);
      void'(expQ.pop_front());
      outCount++;
    end else begin
      check(outValid === 1'b0, "R4 no spurious pulse", {31'b0, outValid}, 32'd0);
    end
  endtask

  // One clock cycle: check, drive, update the behavioural model
  task automatic step(input logic v, input logic [8:0][31:0] d, output bit took);
    bit modelReady, inFlight;
    expT e;
    @(negedge clk);
    checkOut();
    modelReady = (benchPh != 3);
    check(inReady === modelReady, "R2 ready", {31'b0, inReady}, {31'b0, modelReady});
    inValid    = v;
    inOperands = d;
    inFlight   = (lastAcc >= cyc - 6);
    took       = v && modelReady;
    if (took) begin
      e.due = cyc + ((benchPh == 2) ? 6 : 5);
      e.val = refFold(d);
      expQ.push_back(e);
      lastAcc = cyc;
      accCount++;
    end
    if (v || inFlight) benchPh = (benchPh + 1) % 4;
  endtask

  task automatic idle(input int n);
    bit t;
    for (int k = 0; k < n; k++) step(1'b0, '0, t);
  endtask

  initial begin
    bit t;
    int got;
    logic [8:0][31:0] d;
    rstN = 1'b0; inValid = 1'b0; inOperands = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid === 1'b0, "R1 outValid in reset", {31'b0, outValid}, 32'd0);
    check(inReady === 1'b1, "R1 inReady in reset", {31'b0, inReady}, 32'd1);
    rstN = 1'b1;

    // R3 R5: a single set, then drain
    step(1'b1, randSet(), t);
    idle(10);

    // R3: special words (identity map, zero multiplier, all ones)
    for (int k = 0; k < 9; k++) d[k] = 32'h0001_0000 + 32'(k);
    step(1'b1, d, t);
    d = randSet(); d[4] = 32'h0000_1234;
    step(1'b1, d, t);
    d = '1;
    step(1'b1, d, t);
    idle(10);

    // R6 R7: valid held high for 40 cycles, 30 must be taken
    got = 0;
    for (int k = 0; k < 40; k++) begin
      step(1'b1, randSet(), t);
      if (t) got++;
    end
    check(got == 30, "R6 R7 acceptance count", 32'(got), 32'd30);
    idle(12);

    // R9: sparse traffic leaves empty slots
    for (int k = 0; k < 60; k++) step(1'($urandom_range(0, 1)), randSet(), t);
    idle(12);

    // R8: long pause, ready must not move, then resume
    for (int k = 0; k < 5; k++) step(1'b0, '0, t);
    step(1'b1, randSet(), t);
    step(1'b0, '0, t);
    step(1'b1, randSet(), t);
    idle(14);

    // R4: every accepted set produced exactly one result
    check(outCount == accCount && expQ.size() == 0, "R4 result count",
          32'(outCount), 32'(accCount));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule